// File: doc/BRIEF.md
# ADC Conversion Result and Interrupt Register Bank

This block takes finished conversions from an ADC sequencer and keeps them where software can find them. Each of the eight channels has its own result word. One further word always shows the most recent conversion and the channel it came from. For every channel the bank tracks a "fresh result" flag and a "result lost" flag. Both flags also appear together in a single status word.

Software reaches the bank over a plain register port that has separate write and read strobes. The read strobe marks a consuming read: it clears the flags of the word that was read. The flags of the latest-result word also clear whenever the sequencer's control register is written, which the sequencer signals through a strobe. An interrupt-enable word sets which flags drive the single interrupt line. Each channel has its own enable bit, and a separate bit adds the latest-result flag as a source.

Top module: `adc_result_bank`

Address map:

| Word address | Content |
|---|---|
| 0 to 7 | channel result words |
| 8 | latest-result word |
| 9 | status word |
| 10 | interrupt-enable word |
| 11 to 15 | unmapped |

## Requirements
- R1: Reset clears every flag and every stored result. After reset the interrupt-enable word reads 0x100, so only the latest-result source is enabled.
- R2: A result for channel c (res_valid high, res_chan = c) is visible from the next cycle in word c. Word c then holds the fraction in bits 15:6, the DONE flag (bit 31) set, and the lost flag in bit 30. All other bits read 0.
- R3: Word 8 holds the latest result from any channel. It carries the fraction in bits 15:6, the channel number in bits 26:24, DONE in bit 31 and its own lost flag in bit 30.
- R4: A consuming read (reg_rd high) of word c clears DONE and the lost flag of channel c on the next cycle. Other channels are unaffected.
- R5: The DONE and lost flags of word 8 clear after a consuming read of word 8, or after a cycle with ctrl_wr high.
- R6: The lost flag is set when a new result arrives while the target's DONE is still 1 and burst_mode is high. A result that arrives with burst_mode low always leaves the lost flag 0.
- R7: When a clearing event and a new result for the same word fall in one cycle, the new result wins: DONE reads 1 and the lost flag follows R6, using DONE as it was before that cycle.
- R8: Word 9 shows the channel DONE flags in bits 7:0, the channel lost flags in bits 15:8 and the interrupt line in bit 16. All other bits read 0.
- R9: Writing word 10 loads bits 8:0, where bits 7:0 are the per-channel enables and bit 8 is the latest-result enable. Its other bits read 0.
- R10: irq is high exactly when some channel has DONE and its enable set, or when word 8 has DONE and bit 8 of the enable word is set.
- R11: Non-consuming reads have no side effects. This covers reg_rd low, and consuming reads of words 9 and 10. Writes to words other than 10 change nothing, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| res_valid | input | 1 | a conversion result is offered this cycle |
| res_chan | input | 3 | channel of the offered result |
| res_frac | input | 10 | result fraction |
| burst_mode | input | 1 | sequencer is in continuous (burst) conversion |
| ctrl_wr | input | 1 | sequencer control register is being written |
| reg_addr | input | 4 | word address |
| reg_wr | input | 1 | write strobe |
| reg_rd | input | 1 | consuming-read strobe |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| irq | output | 1 | interrupt request |

## Verification
A new result and a clearing event can fall in the same cycle. The clearing event is either a consuming read of the same word or a control write. The bench forces this overlap directly, with a result that lands on the very word being read and on word 8 during ctrl_wr. It also produces the overlap often in long pseudo-random traffic. The outcome is judged against a bench model built from R6 and R7: DONE must read 1, and the lost flag must reflect DONE as it was before the cycle. After every cycle all sixteen words and irq are compared with that model.

// File: rtl/adc_rb_pkg.sv
`timescale 1ns/10ps
package adc_rb_pkg;

    // word format fixed by the register layout
    localparam int FRAC_W       = 10;
    localparam int FRAC_LSB     = 6;
    localparam int CHN_W        = 3;
    localparam int CHN_LSB      = 24;
    localparam int LOST_BIT     = 30;
    localparam int DONE_BIT     = 31;
    localparam int STAT_OVR_LSB = 8;
    localparam int STAT_IRQ_BIT = 16;
    localparam int WORD_W       = 32;

    typedef struct packed {
        logic done;
        logic lost;
    } flags_t;

    typedef struct packed {
        logic [CHN_W-1:0]  chan;
        logic [FRAC_W-1:0] frac;
    } result_t;

    function automatic logic [WORD_W-1:0] chan_word(flags_t f, logic [FRAC_W-1:0] frac);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DONE_BIT] = f.done;
        w[LOST_BIT] = f.lost;
        w[FRAC_LSB +: FRAC_W] = frac;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] glob_word(flags_t f, result_t r);
        logic [WORD_W-1:0] w;
        w = chan_word(f, r.frac);
        w[CHN_LSB +: CHN_W] = r.chan;
        return w;
    endfunction

    // next flags for one result holder; a new result beats any clear
    function automatic flags_t next_flags(flags_t cur, logic load, logic burst, logic clr);
        flags_t n;
        n = cur;
        if (load) begin
            n.lost = burst & cur.done;
            n.done = 1'b1;
        end else if (clr) begin
            n = '0;
        end
        return n;
    endfunction

endpackage

// File: rtl/adc_rb_slot.sv
`timescale 1ns/10ps
module adc_rb_slot
    import adc_rb_pkg::*;
#(
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          burst,
    input  logic          clr,
    input  logic [FW-1:0] frac_in,
    output flags_t        flags,
    output logic [FW-1:0] frac
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            frac  <= '0;
        end else begin
            flags <= next_flags(flags, load, burst, clr);
            if (load) frac <= frac_in;
        end
    end

endmodule

// File: rtl/adc_rb_latest.sv
`timescale 1ns/10ps
module adc_rb_latest
    import adc_rb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    burst,
    input  logic    clr,
    input  result_t res_in,
    output flags_t  flags,
    output result_t res
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            res   <= '0;
        end else begin
            flags <= next_flags(flags, load, burst, clr);
            if (load) res <= res_in;
        end
    end

endmodule

// File: rtl/adc_rb_irqctl.sv
`timescale 1ns/10ps
module adc_rb_irqctl #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic [NUM_CH:0]   en_wdata,
    input  logic [NUM_CH-1:0] done_vec,
    input  logic              glob_done,
    output logic [NUM_CH:0]   en_q,
    output logic              irq
);

    localparam logic [NUM_CH:0] EN_RESET = {1'b1, {NUM_CH{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst)        en_q <= EN_RESET;
        else if (en_wr) en_q <= en_wdata;
    end

    always_comb begin
        irq = |(done_vec & en_q[NUM_CH-1:0]);
        if (en_q[NUM_CH] && glob_done) irq = 1'b1;
    end

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/10ps
module adc_result_bank
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 res_valid,
    input  logic [CHN_W-1:0]     res_chan,
    input  logic [FRAC_W-1:0]    res_frac,
    input  logic                 burst_mode,
    input  logic                 ctrl_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 irq
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] A_GLOB = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_CH + 2);

    logic [NUM_CH-1:0]  chan_done;
    logic [NUM_CH-1:0]  chan_lost;
    logic [WORD_W-1:0]  chan_words [NUM_CH];
    flags_t             glob_flags;
    result_t            glob_res;
    logic               glob_done;
    logic [NUM_CH:0]    ien_q;
    logic               in_chan_range;

    assign in_chan_range = (reg_addr < A_GLOB);

    // per-channel holders
    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        logic               ld;
        logic               clr;
        flags_t             fl;
        logic [FRAC_W-1:0]  fr;

        assign ld  = res_valid && (res_chan == CHN_W'(c));
        assign clr = reg_rd && (reg_addr == ADDR_W'(c));

        adc_rb_slot #(.FW(FRAC_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .load    (ld),
            .burst   (burst_mode),
            .clr     (clr),
            .frac_in (res_frac),
            .flags   (fl),
            .frac    (fr)
        );

        assign chan_done[c]  = fl.done;
        assign chan_lost[c]  = fl.lost;
        assign chan_words[c] = chan_word(fl, fr);
    end

    // latest-result holder
    logic    glob_clr;
    result_t glob_in;
    assign glob_clr = ctrl_wr || (reg_rd && reg_addr == A_GLOB);
    assign glob_in  = '{chan: res_chan, frac: res_frac};

    adc_rb_latest u_latest (
        .clk    (clk),
        .rst    (rst),
        .load   (res_valid),
        .burst  (burst_mode),
        .clr    (glob_clr),
        .res_in (glob_in),
        .flags  (glob_flags),
        .res    (glob_res)
    );
    assign glob_done = glob_flags.done;

    // interrupt enables and request
    adc_rb_irqctl #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (reg_wr && reg_addr == A_IEN),
        .en_wdata  (reg_wdata[NUM_CH:0]),
        .done_vec  (chan_done),
        .glob_done (glob_done),
        .en_q      (ien_q),
        .irq       (irq)
    );

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[WORD_W-1:NUM_CH+1];

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (in_chan_range) begin
            reg_rdata = chan_words[reg_addr[CH_W-1:0]];
        end else if (reg_addr == A_GLOB) begin
            reg_rdata = glob_word(glob_flags, glob_res);
        end else if (reg_addr == A_STAT) begin
            reg_rdata[NUM_CH-1:0]                 = chan_done;
            reg_rdata[STAT_OVR_LSB +: NUM_CH]     = chan_lost;
            reg_rdata[STAT_IRQ_BIT]               = irq;
        end else if (reg_addr == A_IEN) begin
            reg_rdata[NUM_CH:0] = ien_q;
        end
    end

endmodule

// File: rtl/adc_result_bank_chk.sv
`timescale 1ns/10ps
module adc_result_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4,
    parameter int CHN_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic [CHN_W-1:0]  res_chan,
    input logic              burst_mode,
    input logic              ctrl_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_CH-1:0] done_vec,
    input logic [NUM_CH-1:0] lost_vec,
    input logic              glob_done,
    input logic [NUM_CH:0]   ien,
    input logic              irq
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (done_vec == '0 && lost_vec == '0 && !glob_done
                        && ien == {1'b1, {NUM_CH{1'b0}}}));

    assert_done_on_result_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> done_vec[$past(res_chan)]);

    assert_latest_done_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> glob_done);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr < ADDR_W'(NUM_CH) &&
         !(res_valid && CHN_W'(reg_addr) == res_chan))
        |=> (!done_vec[$past(reg_addr[CHN_W-1:0])] && !lost_vec[$past(reg_addr[CHN_W-1:0])]));

    assert_ctrl_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !res_valid) |=> !glob_done);

    assert_no_lost_single_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !burst_mode) |=> !lost_vec[$past(res_chan)]);

    assert_lost_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_vec[0]) |-> $past(done_vec[0]) && $past(burst_mode));

    assert_result_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ctrl_wr) |=> glob_done);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (done_vec == '0 && !glob_done) |-> !irq);

    assert_irq_global_R10: assert property (@(posedge clk) disable iff (rst)
        (glob_done && ien[NUM_CH]) |-> irq);

endmodule

bind adc_result_bank adc_result_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CHN_W(adc_rb_pkg::CHN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .res_valid  (res_valid),
    .res_chan   (res_chan),
    .burst_mode (burst_mode),
    .ctrl_wr    (ctrl_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .done_vec   (chan_done),
    .lost_vec   (chan_lost),
    .glob_done  (glob_done),
    .ien        (ien_q),
    .irq        (irq)
);

// File: tb/adc_result_bank_tb.sv
`timescale 1ns/10ps
module adc_result_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [2:0]  res_chan = '0;
    logic [9:0]  res_frac = '0;
    logic        burst_mode = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_result_bank u_dut (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
        .res_frac(res_frac), .burst_mode(burst_mode), .ctrl_wr(ctrl_wr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // bench model, built from the requirements
    logic [9:0] m_frac [8];
    logic       m_done [8];
    logic       m_lost [8];
    logic [9:0] g_frac;
    logic [2:0] g_chan;
    logic       g_done, g_lost;
    logic [8:0] m_ien;
    logic [15:0] lfsr = 16'hACE1;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_frac[i] = '0; m_done[i] = 0; m_lost[i] = 0;
        end
        g_frac = '0; g_chan = '0; g_done = 0; g_lost = 0; m_ien = 9'h100;
    endtask

    function automatic logic exp_irq();
        logic r;
        r = m_ien[8] & g_done;
        for (int i = 0; i < 8; i++) r |= m_ien[i] & m_done[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_word(int a);
        logic [31:0] w;
        w = '0;
        if (a < 8) begin
            w[31] = m_done[a]; w[30] = m_lost[a]; w[15:6] = m_frac[a];
        end else if (a == 8) begin
            w[31] = g_done; w[30] = g_lost; w[26:24] = g_chan; w[15:6] = g_frac;
        end else if (a == 9) begin
            for (int i = 0; i < 8; i++) begin
                w[i] = m_done[i]; w[8+i] = m_lost[i];
            end
            w[16] = exp_irq();
        end else if (a == 10) begin
            w[8:0] = m_ien;
        end
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek(int a, output logic [31:0] v);
        reg_addr = 4'(a);
        #0.25;
        v = reg_rdata;
    endtask

    task automatic verify_all();
        logic [31:0] v;
        string tag;
        for (int a = 0; a < 16; a++) begin
            peek(a, v);
            if (a < 8)        tag = "R2 chan word";
            else if (a == 8)  tag = "R3 latest word";
            else if (a == 9)  tag = "R8 status word";
            else if (a == 10) tag = "R9 enable word";
            else              tag = "R11 unmapped";
            chk(tag, v, exp_word(a));
        end
        chk("R10 irq", {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    // one clock with the given stimulus; model follows R2..R9, R11
    task automatic cyc(bit v, int ch, logic [9:0] fr, bit burst, bit cw,
                       bit rd, bit wr, int addr, logic [31:0] wd);
        res_valid = v; res_chan = 3'(ch); res_frac = fr; burst_mode = burst;
        ctrl_wr = cw; reg_rd = rd; reg_wr = wr; reg_addr = 4'(addr); reg_wdata = wd;
        for (int i = 0; i < 8; i++) begin
            if (v && ch == i) begin
                m_lost[i] = burst & m_done[i]; m_done[i] = 1; m_frac[i] = fr;
            end else if (rd && addr == i) begin
                m_done[i] = 0; m_lost[i] = 0;
            end
        end
        if (v) begin
            g_lost = burst & g_done; g_done = 1; g_frac = fr; g_chan = 3'(ch);
        end else if (cw || (rd && addr == 8)) begin
            g_done = 0; g_lost = 0;
        end
        if (wr && addr == 10) m_ien = wd[8:0];
        @(posedge clk);
        #1;
        res_valid = 0; ctrl_wr = 0; reg_rd = 0; reg_wr = 0;
        verify_all();
    endtask

    function automatic logic [15:0] step_lfsr(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(posedge clk); #1;
        // R1
        peek(10, v); chk("R1 enable reset", v, 32'h100);
        peek(9, v);  chk("R1 status reset", v, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        verify_all();

        // R2/R3: every channel, single-shot
        for (int c = 0; c < 8; c++) begin
            cyc(1, c, 10'(37 * c + 5), 0, 0, 0, 0, 0, 0);
            peek(c, v); chk("R2 done and fraction", v, {1'b1, 1'b0, 14'b0, 10'(37 * c + 5), 6'b0});
            peek(8, v); chk("R3 latest carries channel", v,
                            {1'b1, 1'b0, 3'b0, 3'(c), 8'b0, 10'(37 * c + 5), 6'b0});
        end
        // R6: second result without burst leaves lost 0
        cyc(1, 2, 10'h3FF, 0, 0, 0, 0, 0, 0);
        peek(2, v); chk("R6 no lost outside burst", v[31:30], 32'h2);
        // R6: burst over an unread result sets lost
        cyc(1, 2, 10'h155, 1, 0, 0, 0, 0, 0);
        peek(2, v); chk("R6 lost in burst", v[31:30], 32'h3);
        peek(9, v); chk("R8 status lost bit", {31'b0, v[10]}, 32'h1);
        // R4: consuming read clears channel 2 only
        cyc(0, 0, 0, 0, 0, 1, 0, 2, 0);
        peek(2, v); chk("R4 flags cleared", v[31:30], 32'h0);
        peek(3, v); chk("R4 neighbour untouched", {31'b0, v[31]}, 32'h1);
        // R7: read and new result on the same word
        cyc(1, 3, 10'h0AA, 1, 0, 1, 0, 3, 0);
        peek(3, v); chk("R7 result wins", v, {2'b11, 14'b0, 10'h0AA, 6'b0});
        // R7 on latest word with ctrl_wr
        cyc(1, 4, 10'h011, 0, 1, 0, 0, 0, 0);
        peek(8, v); chk("R7 latest result wins ctrl", {31'b0, v[31]}, 32'h1);
        // R5: ctrl_wr clears latest
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        peek(8, v); chk("R5 ctrl clears", {31'b0, v[31]}, 32'h0);
        // R10: only channel enable 5, latest enable off
        cyc(0, 0, 0, 0, 0, 0, 1, 10, 32'hFFFF_FE20);
        chk("R10 irq from ch5", {31'b0, irq}, 32'h1);
        cyc(0, 0, 0, 0, 0, 1, 0, 5, 0);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        // R11: write to data word and consuming status read change nothing
        cyc(0, 0, 0, 0, 0, 1, 1, 9, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
        peek(1, v); chk("R11 data write ignored", v, {1'b1, 1'b0, 14'b0, 10'(42), 6'b0});
        cyc(1, 6, 10'h123, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 8, 0);
        peek(8, v); chk("R5 latest read clears", {31'b0, v[31]}, 32'h0);

        // pseudo-random traffic with model comparison every cycle
        for (int n = 0; n < 1500; n++) begin
            logic [15:0] a, b;
            lfsr = step_lfsr(lfsr); a = lfsr;
            lfsr = step_lfsr(lfsr); b = lfsr;
            cyc(a[0] | a[1], int'(a[4:2]), b[9:0], a[5] | a[6], a[7] & a[8] & a[9],
                a[10], a[11] & a[12], int'(b[13:10]) % 11, {b[15:7], b[15:0], a[15:9]});
        end

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule